// File: doc/BRIEF.md
# Programmable Skew Output Matrix

This block is a cycle-accurate digital model of a four-bank clock output stage. A fast tick clock gives one tick per time unit. A phase counter spans one nominal output period of N ticks. A three-level range select picks N. Each bank drives a pair of identical outputs. Two three-level selects per bank choose one of nine functions: a square wave shifted by a signed number of time units, a divided clock, or an inverted clock.

The outer banks (A, B) shift in single time units. The inner banks (C, D) shift in steps of two time units. In the inner banks the two extreme codes are replaced by divide or invert functions.

Further inputs set the reference edge polarity and a synchronous stop for every bank except C, so that C can keep feeding a loop back. A bypass mode routes a reference input straight to the banks. Configuration is sampled only at the period boundary, so a select change never cuts a pulse short.

Top module: `skew_matrix`

## Requirements
- R1: The period N is 44 ticks for range code 00, 26 for 01 and 16 for 10. A zero-shift output (selects 01/01) is high for the N/2 ticks starting at phase 0. Every output is registered and reflects the phase count one tick earlier.
- R2: In banks A and B the function index is 3*L(sel[3:2]) + L(sel[1:0]), where L maps 00 to 0, 01 to 1 and 10 to 2. Index i gives a shift of (i - 4) time units, and the output is high while ((phase - shift) mod N) < N/2.
- R3: In bank C, index 0 gives divide-by-2, index 8 gives divide-by-4, and index i from 1 to 7 gives a shift of 2*(i - 4) time units.
- R4: In bank D, index 0 gives divide-by-2, index 8 gives the inverse of the zero-shift output, and index i from 1 to 7 gives a shift of 2*(i - 4) time units.
- R5: Every three-level input takes 00 as LOW, 01 as MID and 10 as HIGH. The code 11 behaves exactly like MID, both for the bank selects and for the range select.
- R6: When out_stop is high, banks A, B and D go low on the next tick while it stays high. Bank C keeps running.
- R7: With edge_rise high the waveforms are as stated above. With edge_rise low every shifted and inverted waveform is complemented, so that its falling edge lands where the rising edge would be. Divided outputs are not complemented.
- R8: Both dividers advance on the alignment event, which is phase 0 in normal mode. Divide-by-2 toggles on every event. Divide-by-4 toggles only on the events where divide-by-2 rises, so the rising edges of the two dividers coincide.
- R9: When test_sel is not 00, the reference input replaces the phase waveform. Every shift function outputs ref_in, complemented when edge_rise is low. The invert function outputs the complement of that. The dividers advance on the rising edge of ref_in (falling when edge_rise is low).
- R10: Changes to range_sel or to any bank select take effect only when the phase counter wraps from N-1 to 0.
- R11: A synchronous reset forces all outputs low, clears the phase counter and the dividers, and loads the current configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per time unit |
| rst | input | 1 | Synchronous reset, active high |
| range_sel | input | 2 | Three-level period range select |
| test_sel | input | 2 | Three-level bypass select; non-LOW enables bypass |
| edge_rise | input | 1 | Reference edge polarity; high selects rising |
| out_stop | input | 1 | Stops banks A, B and D low when high |
| ref_in | input | 1 | Reference input used in bypass mode |
| sel_a | input | 4 | Bank A selects {sel1, sel0}, 2 bits each |
| sel_b | input | 4 | Bank B selects |
| sel_c | input | 4 | Bank C selects |
| sel_d | input | 4 | Bank D selects |
| q_a | output | 2 | Bank A output pair |
| q_b | output | 2 | Bank B output pair |
| q_c | output | 2 | Bank C output pair |
| q_d | output | 2 | Bank D output pair |

## Verification
The assertions check on every cycle that the phase counter stays below the period and restarts at zero after a wrap. They also check that the latched configuration holds between wraps, that a divide-by-4 rise always comes with a divide-by-2 rise, that reset and the stop input force the right banks low, and that bank C keeps toggling while stopped. Only the bench's scenarios can show that each of the nine codes per bank produces the correct shift or special function. The same holds for the three period lengths, the complemented waveforms under falling polarity, the 11-as-MID handling and the bypass path under a toggling reference.

// File: rtl/skew_pkg.sv
package skew_pkg;

  typedef enum logic [1:0] {
    FN_SKEW = 2'd0,
    FN_DIV2 = 2'd1,
    FN_DIV4 = 2'd2,
    FN_INV  = 2'd3
  } bank_fn_e;

  typedef struct packed {
    bank_fn_e          fn;
    logic signed [4:0] shift;
  } bank_fn_t;

  // Three-level level: 00 low, 10 high, 01 and 11 mid.
  function automatic logic [1:0] tri_level(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b10:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // Nine-way function index from {sel1, sel0}.
  function automatic logic [3:0] fn_index(input logic [3:0] sel);
    logic [3:0] hi;
    hi = {2'b00, tri_level(sel[3:2])};
    return (hi << 1) + hi + {2'b00, tri_level(sel[1:0])};
  endfunction

  function automatic bank_fn_t decode_fn(input logic [3:0] idx,
                                         input logic inner,
                                         input logic hh_inv);
    bank_fn_t r;
    int       v;
    v = int'(idx) - 4;
    if (inner) v = v * 2;
    r.fn    = FN_SKEW;
    r.shift = 5'(v);
    if (inner && idx == 4'd0) r.fn = FN_DIV2;
    if (inner && idx == 4'd8) r.fn = hh_inv ? FN_INV : FN_DIV4;
    return r;
  endfunction

  function automatic int period_of(input logic [1:0] range_code,
                                   input int n_low, input int n_mid,
                                   input int n_high);
    case (tri_level(range_code))
      2'd0:    return n_low;
      2'd2:    return n_high;
      default: return n_mid;
    endcase
  endfunction

  // High while the phase, moved back by the shift, lies in the first half.
  function automatic logic shifted_high(input int cnt, input int n,
                                        input int shift);
    int p;
    p = cnt + n - shift;
    if (p >= n) p = p - n;
    if (p >= n) p = p - n;
    return p < (n / 2);
  endfunction

endpackage

// File: rtl/skew_phase_gen.sv
module skew_phase_gen
  import skew_pkg::*;
#(
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16,
  parameter int BANKS  = 4,
  parameter int CW     = $clog2(N_LOW + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           range_sel,
  input  logic [4*BANKS-1:0]   sel_in,
  input  logic                 bypass,
  input  logic                 edge_rise,
  input  logic                 ref_in,
  output logic [CW-1:0]        cnt,
  output logic [CW-1:0]        period,
  output logic [4*BANKS-1:0]   sel_cfg,
  output logic                 div2_nx,
  output logic                 div4_nx
);

  logic [1:0] range_cfg;
  logic       wrap;
  logic       div2, div4;
  logic       ref_d;
  logic       align_ev;

  assign period = CW'(period_of(range_cfg, N_LOW, N_MID, N_HIGH));
  assign wrap   = (cnt == period - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      range_cfg <= range_sel;
      sel_cfg   <= sel_in;
    end
    if (rst || wrap) cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

  always_comb begin
    if (bypass) align_ev = edge_rise ? (ref_in & ~ref_d) : (~ref_in & ref_d);
    else        align_ev = (cnt == '0);
    div2_nx = align_ev ? ~div2 : div2;
    div4_nx = (align_ev && !div2) ? ~div4 : div4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div2  <= 1'b0;
      div4  <= 1'b0;
      ref_d <= 1'b0;
    end else begin
      div2  <= div2_nx;
      div4  <= div4_nx;
      ref_d <= ref_in;
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt < period);

  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  p_div_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(div4) |-> $rose(div2));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrap)) |-> ($stable(range_cfg) && $stable(sel_cfg)));

endmodule

// File: rtl/skew_bank.sv
module skew_bank
  import skew_pkg::*;
#(
  parameter bit INNER     = 1'b0,
  parameter bit HH_INV    = 1'b0,
  parameter bit OE_EXEMPT = 1'b0,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    sel,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] period,
  input  logic          bypass,
  input  logic          edge_rise,
  input  logic          ref_in,
  input  logic          out_stop,
  input  logic          div2_nx,
  input  logic          div4_nx,
  output logic [1:0]    q
);

  bank_fn_t f;
  logic     zero_w, skew_w, out_v;

  always_comb begin
    f = decode_fn(fn_index(sel), INNER, HH_INV);
    if (bypass) begin
      zero_w = ref_in;
      skew_w = ref_in;
    end else begin
      zero_w = shifted_high(int'(cnt), int'(period), 0);
      skew_w = shifted_high(int'(cnt), int'(period), int'(f.shift));
    end
    if (!edge_rise) begin
      zero_w = ~zero_w;
      skew_w = ~skew_w;
    end
    case (f.fn)
      FN_DIV2: out_v = div2_nx;
      FN_DIV4: out_v = div4_nx;
      FN_INV:  out_v = ~zero_w;
      default: out_v = skew_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                       q <= 2'b00;
    else if (out_stop && !OE_EXEMPT) q <= 2'b00;
    else                           q <= {out_v, out_v};
  end

endmodule

// File: rtl/skew_matrix.sv
module skew_matrix
  import skew_pkg::*;
#(
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] range_sel,
  input  logic [1:0] test_sel,
  input  logic       edge_rise,
  input  logic       out_stop,
  input  logic       ref_in,
  input  logic [3:0] sel_a,
  input  logic [3:0] sel_b,
  input  logic [3:0] sel_c,
  input  logic [3:0] sel_d,
  output logic [1:0] q_a,
  output logic [1:0] q_b,
  output logic [1:0] q_c,
  output logic [1:0] q_d
);

  localparam int BANKS = 4;
  localparam int CW    = $clog2(N_LOW + 1);

  logic [CW-1:0]      cnt, period;
  logic [4*BANKS-1:0] sel_cfg;
  logic               div2_nx, div4_nx;
  logic               bypass;
  logic [1:0]         q_all [BANKS];

  assign bypass = (test_sel != 2'b00);

  skew_phase_gen #(
    .N_LOW(N_LOW), .N_MID(N_MID), .N_HIGH(N_HIGH), .BANKS(BANKS), .CW(CW)
  ) u_phase (
    .clk(clk), .rst(rst), .range_sel(range_sel),
    .sel_in({sel_d, sel_c, sel_b, sel_a}),
    .bypass(bypass), .edge_rise(edge_rise), .ref_in(ref_in),
    .cnt(cnt), .period(period), .sel_cfg(sel_cfg),
    .div2_nx(div2_nx), .div4_nx(div4_nx)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    skew_bank #(
      .INNER(b >= 2), .HH_INV(b == 3), .OE_EXEMPT(b == 2), .CW(CW)
    ) u_bank (
      .clk(clk), .rst(rst), .sel(sel_cfg[4*b +: 4]),
      .cnt(cnt), .period(period), .bypass(bypass),
      .edge_rise(edge_rise), .ref_in(ref_in), .out_stop(out_stop),
      .div2_nx(div2_nx), .div4_nx(div4_nx), .q(q_all[b])
    );
  end

  assign q_a = q_all[0];
  assign q_b = q_all[1];
  assign q_c = q_all[2];
  assign q_d = q_all[3];

  p_stop_low_r6: assert property (@(posedge clk) disable iff (rst)
    $past(out_stop) |-> (q_a == 2'b00 && q_b == 2'b00 && q_d == 2'b00));

  p_c_live_r6: assert property (@(posedge clk) disable iff (rst)
    (out_stop && !bypass && sel_cfg[11:8] == 4'b0101 && cnt == '0 && $past(cnt) != '0)
      |=> (q_c == 2'b11));

  p_reset_low_r11: assert property (@(posedge clk)
    rst |=> (q_a == 2'b00 && q_b == 2'b00 && q_c == 2'b00 && q_d == 2'b00));

endmodule

// File: tb/tb_skew_matrix.sv
module tb_skew_matrix;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] range_sel = 2'b10;
  logic [1:0] test_sel  = 2'b00;
  logic       edge_rise = 1'b1;
  logic       out_stop  = 1'b0;
  logic       ref_in    = 1'b0;
  logic [3:0] sel_a = 4'b0101, sel_b = 4'b0101, sel_c = 4'b0101, sel_d = 4'b0101;
  logic [1:0] q_a, q_b, q_c, q_d;

  skew_matrix dut (
    .clk(clk), .rst(rst), .range_sel(range_sel), .test_sel(test_sel),
    .edge_rise(edge_rise), .out_stop(out_stop), .ref_in(ref_in),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_d(sel_d),
    .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_d(q_d)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  exp_t scb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // Bench-side model state
  int         m_cnt;
  logic       m_d2, m_d4, m_refd;
  logic [1:0] m_rng;
  logic [3:0] m_sel [4];

  function automatic int lvl(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b10) return 2;
    return 1;
  endfunction

  function automatic int nper(input logic [1:0] r);
    case (lvl(r))
      0: return 44;
      2: return 16;
      default: return 26;
    endcase
  endfunction

  function automatic logic [3:0] code(input int i);
    logic [1:0] e [3];
    e[0] = 2'b00; e[1] = 2'b01; e[2] = 2'b10;
    return {e[i / 3], e[i % 3]};
  endfunction

  function automatic logic bank_exp(input int b, input logic [3:0] s, input int c,
                                    input int n, input logic byp, input logic pol,
                                    input logic r, input logic n2, input logic n4);
    int   idx, k;
    logic base, w;
    idx  = 3 * lvl(s[3:2]) + lvl(s[1:0]);
    base = byp ? r : (c < n / 2);
    if (!pol) base = !base;
    if (b < 2) k = idx - 4;
    else begin
      if (idx == 0) return n2;
      if (idx == 8) return (b == 2) ? n4 : !base;
      k = 2 * (idx - 4);
    end
    w = byp ? r : ((((c - k) % n) + n) % n < n / 2);
    return pol ? w : !w;
  endfunction

  task automatic load_cfg();
    m_rng = range_sel;
    m_sel[0] = sel_a; m_sel[1] = sel_b; m_sel[2] = sel_c; m_sel[3] = sel_d;
  endtask

  task automatic step(input string tag);
    exp_t e;
    logic byp, ev, n2, n4;
    int   n;
    logic bits [4];
    n   = nper(m_rng);
    byp = (test_sel != 2'b00);
    if (byp) ev = edge_rise ? (ref_in && !m_refd) : (!ref_in && m_refd);
    else     ev = (m_cnt == 0);
    n2 = ev ? !m_d2 : m_d2;
    n4 = (ev && !m_d2) ? !m_d4 : m_d4;
    for (int b = 0; b < 4; b++) begin
      bits[b] = bank_exp(b, m_sel[b], m_cnt, n, byp, edge_rise, ref_in, n2, n4);
      if (out_stop && b != 2) bits[b] = 1'b0;
    end
    e.v   = {bits[3], bits[3], bits[2], bits[2], bits[1], bits[1], bits[0], bits[0]};
    e.tag = tag;
    scb.push_back(e);
    m_d2 = n2; m_d4 = n4; m_refd = ref_in;
    if (m_cnt == n - 1) begin
      m_cnt = 0;
      load_cfg();
    end else m_cnt = m_cnt + 1;
  endtask

  task automatic run(input int cycles, input string tag, input int ref_half);
    for (int i = 0; i < cycles; i++) begin
      if (ref_half > 0 && i % ref_half == 0) ref_in = !ref_in;
      step(tag);
      @(negedge clk);
    end
  endtask

  // Monitor: pops one expected item per active clock and compares.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (scb.size() > 0) begin
      e = scb.pop_front();
      checks++;
      if ({q_d, q_c, q_b, q_a} !== e.v) begin
        fails++;
        $display("FAIL %s: outputs {d,c,b,a}=%b expected %b at %0t",
                 e.tag, {q_d, q_c, q_b, q_a}, e.v, $time);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({q_d, q_c, q_b, q_a} !== 8'h00) begin
      fails++;
      $display("FAIL R11: reset outputs %b expected %b", {q_d, q_c, q_b, q_a}, 8'h00);
    end
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_d2 = 0; m_d4 = 0; m_refd = 0;
    load_cfg();

    // R1: period lengths per range code
    run(3 * 16, "R1", 0);
    range_sel = 2'b01;
    run(3 * 26 + 16, "R1", 0);
    range_sel = 2'b00;
    run(3 * 44 + 26, "R1", 0);
    range_sel = 2'b10;
    run(44, "R1", 0);

    // R2 R3 R4: all nine codes per bank
    for (int i = 0; i < 9; i++) begin
      sel_a = code(i); sel_b = code(8 - i); sel_c = code(i); sel_d = code((i + 4) % 9);
      run((i == 0 || i == 8) ? 80 : 40, "R2/R3/R4", 0);
    end

    // R5: 11 treated as MID on selects and range
    sel_a = 4'b1100; sel_b = 4'b1111; sel_c = 4'b0011; sel_d = 4'b1011;
    run(40, "R5", 0);
    range_sel = 2'b11;
    run(16 + 3 * 26, "R5", 0);
    range_sel = 2'b10;
    run(26, "R5", 0);

    // R7: falling-edge alignment
    edge_rise = 1'b0;
    sel_a = code(1); sel_b = code(7); sel_c = code(0); sel_d = code(8);
    run(80, "R7", 0);
    sel_c = code(2); sel_d = code(6);
    run(40, "R7", 0);
    edge_rise = 1'b1;

    // R6: stop holds A, B, D low; C keeps running
    sel_a = code(5); sel_b = code(3); sel_c = code(4); sel_d = code(4);
    run(20, "R6", 0);
    out_stop = 1'b1;
    run(48, "R6", 0);
    sel_c = code(0);
    run(40, "R6", 0);
    out_stop = 1'b0;
    run(20, "R6", 0);

    // R8: dividers with coinciding rising edges
    sel_c = code(8); sel_d = code(0);
    run(6 * 16, "R8", 0);

    // R10: mid-period select change waits for the wrap
    sel_a = code(4); sel_c = code(4);
    run(16 + (16 - m_cnt), "R10", 0);
    run(5, "R10", 0);
    sel_a = code(8); sel_c = code(1);
    run(30, "R10", 0);

    // R9: bypass with a toggling reference
    test_sel = 2'b01;
    sel_a = code(0); sel_b = code(6); sel_c = code(8); sel_d = code(8);
    run(60, "R9", 3);
    sel_c = code(0); sel_d = code(0);
    run(40, "R9", 5);
    test_sel = 2'b10;
    edge_rise = 1'b0;
    run(60, "R9", 2);
    sel_c = code(8); sel_d = code(8);
    run(60, "R9", 4);
    test_sel = 2'b00;
    edge_rise = 1'b1;
    run(40, "R9", 0);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule